// File: doc/BRIEF.md
# Table-Indexed Call, Switch and Return Target Unit

This unit produces the next program counter for four control-flow operations that a decoder hands to it: a call through a halfword offset table, a switch jump through a halfword displacement table that follows the jump, a return from a table call, and a return from an exception. The two table-based operations each read one halfword from memory. Each return operation takes its target and restored status word from saved registers held inside the unit.

The unit keeps the call-table base register. It also keeps the PC and status word saved by the most recent table call, plus the PC/status pairs for normal and fatal exceptions. The decoder loads the base register and the two exception pairs through the same request port, using dedicated operation codes. When a table-based operation is accepted, the unit raises a read request. It holds that request until memory acknowledges it, then issues a one-cycle PC-update strobe carrying the computed target. A return issues its strobe, together with a status-write strobe, in the cycle after acceptance. No request is accepted while a table read is outstanding.

Top module: `tbl_branch_unit`

## Requirements
- R1: After reset `busy`, `mem_rd_valid`, `pc_upd` and `stat_wr` are low, and `ctx_pc` and `ctx_stat` read zero.
- R2: A table call (op 0) reads the halfword at (base with bit 0 cleared) + (low six bits of `req_opnd` shifted left by one). `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen.
- R3: In the cycle after a table call is accepted, `ctx_pc` shows `req_pc`+2 and `ctx_stat` shows `req_stat`.
- R4: A table call's target is (base with bit 0 cleared) plus the fetched halfword with its bit 0 cleared, zero-extended.
- R5: A switch jump (op 1) reads at (`req_pc`+2) + (`req_opnd` << 1). Its target is (`req_pc`+2) plus the sign-extended halfword shifted left by one.
- R6: The cycle after the read handshake, `pc_upd` is high for that cycle with the target on `pc_next`. `stat_wr` stays low for calls and switch jumps.
- R7: `busy` is high from the cycle after a table read is accepted until the handshake. A request presented while `busy` is high is dropped and produces no strobe.
- R8: A table-call return (op 2) raises `pc_upd` and `stat_wr` in the cycle after acceptance. `pc_next` is the saved call PC with bit 0 cleared, and `stat_next` is the saved call status ANDed with `STAT_MASK`.
- R9: An exception return (op 3) uses the exception pair when status bit `EP_BIT` is set. It uses the fatal pair when `EP_BIT` is clear and `NP_BIT` is set. It uses the exception pair when both are clear. The PC has bit 0 cleared and the status is restored unmasked.
- R10: Op 4 loads the base from `req_opnd`. Op 5 and op 6 load the exception pair and the fatal pair from `req_opnd`/`req_stat`. None of these, and not op 7, raises any strobe.
- R11: Two returns on consecutive cycles produce strobes on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_pc | input | XW | Address of the current instruction |
| req_opnd | input | XW | Index, register value or load value |
| req_stat | input | XW | Current status word or load value |
| busy | output | 1 | Table read outstanding |
| mem_rd_valid | output | 1 | Halfword read request |
| mem_rd_addr | output | XW | Read address |
| mem_rd_ready | input | 1 | Read accepted, data valid |
| mem_rd_data | input | 16 | Read halfword |
| pc_upd | output | 1 | One-cycle PC-update strobe |
| pc_next | output | XW | New PC |
| stat_wr | output | 1 | Status restore strobe |
| stat_next | output | XW | Restored status word |
| ctx_pc | output | XW | Saved call-return PC |
| ctx_stat | output | XW | Saved call status |

## Verification
The bench builds the unit with a 32-bit datapath, EP and NP at bits 6 and 7, and a mask of 0x0F0F. With that mask, a saved status of all ones returns a value that shows whether masking took place. Memory latency is varied between zero and three cycles, so the bench covers both an immediate handshake and a long wait with a dropped request during it. The table offsets used are 0xFFFF and 0xFFFE, so the sign extension, the bit-0 clearing and the maximum six-bit index all affect the observed targets.

// File: rtl/tbru_pkg.sv
package tbru_pkg;

    typedef enum logic [2:0] {
        OP_TCALL   = 3'd0,
        OP_SWJMP   = 3'd1,
        OP_TRET    = 3'd2,
        OP_XRET    = 3'd3,
        OP_SETBASE = 3'd4,
        OP_SETEXC  = 3'd5,
        OP_SETFEX  = 3'd6,
        OP_NONE    = 3'd7
    } tbru_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } tbru_state_e;

    localparam int HALF_W = 16;

endpackage

// File: rtl/tbru_ctx_regs.sv
module tbru_ctx_regs #(
    parameter int XW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_base,
    input  logic [XW-1:0] base_in,
    input  logic          save_call,
    input  logic [XW-1:0] call_pc_in,
    input  logic [XW-1:0] call_stat_in,
    input  logic          wr_exc,
    input  logic          wr_fex,
    input  logic [XW-1:0] pair_pc_in,
    input  logic [XW-1:0] pair_stat_in,
    output logic [XW-1:0] base,
    output logic [XW-1:0] ct_pc,
    output logic [XW-1:0] ct_stat,
    output logic [XW-1:0] ex_pc,
    output logic [XW-1:0] ex_stat,
    output logic [XW-1:0] fx_pc,
    output logic [XW-1:0] fx_stat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base    <= '0;
            ct_pc   <= '0;
            ct_stat <= '0;
            ex_pc   <= '0;
            ex_stat <= '0;
            fx_pc   <= '0;
            fx_stat <= '0;
        end else begin
            if (wr_base) base <= base_in;
            if (save_call) begin
                ct_pc   <= call_pc_in;
                ct_stat <= call_stat_in;
            end
            if (wr_exc) begin
                ex_pc   <= pair_pc_in;
                ex_stat <= pair_stat_in;
            end
            if (wr_fex) begin
                fx_pc   <= pair_pc_in;
                fx_stat <= pair_stat_in;
            end
        end
    end
endmodule

// File: rtl/tbru_addr_gen.sv
module tbru_addr_gen #(
    parameter int XW    = 32,
    parameter int IDX_W = 6
) (
    input  logic                        is_call,
    input  logic [XW-1:0]               base,
    input  logic [XW-1:0]               pc,
    input  logic [XW-1:0]               opnd,
    input  logic [tbru_pkg::HALF_W-1:0] rdata,
    output logic [XW-1:0]               fetch_addr,
    output logic [XW-1:0]               target
);
    localparam int HW = tbru_pkg::HALF_W;
    localparam logic [XW-1:0] ONE = XW'(1);
    localparam logic [XW-1:0] TWO = XW'(2);

    logic [XW-1:0] base_even;
    logic [XW-1:0] after_pc;
    logic [XW-1:0] idx_off;
    logic [XW-1:0] call_off;
    logic [XW-1:0] sw_off;

    always_comb begin
        base_even = base & ~ONE;
        after_pc  = pc + TWO;
        idx_off   = XW'(opnd[IDX_W-1:0]) << 1;
        call_off  = XW'(rdata & ~HW'(1));
        sw_off    = {{(XW-HW-1){rdata[HW-1]}}, rdata, 1'b0};
        if (is_call) begin
            fetch_addr = base_even + idx_off;
            target     = base_even + call_off;
        end else begin
            fetch_addr = after_pc + (opnd << 1);
            target     = after_pc + sw_off;
        end
    end
endmodule

// File: rtl/tbru_ret_sel.sv
module tbru_ret_sel #(
    parameter int            XW        = 32,
    parameter int            EP_BIT    = 6,
    parameter int            NP_BIT    = 7,
    parameter logic [XW-1:0] STAT_MASK = XW'(32'h0000_00FF)
) (
    input  logic          is_xret,
    input  logic [XW-1:0] cur_stat,
    input  logic [XW-1:0] ct_pc,
    input  logic [XW-1:0] ct_stat,
    input  logic [XW-1:0] ex_pc,
    input  logic [XW-1:0] ex_stat,
    input  logic [XW-1:0] fx_pc,
    input  logic [XW-1:0] fx_stat,
    output logic [XW-1:0] ret_pc,
    output logic [XW-1:0] ret_stat
);
    localparam logic [XW-1:0] ONE = XW'(1);

    logic use_fatal;
    logic [XW-1:0] raw_pc;

    always_comb begin
        use_fatal = !cur_stat[EP_BIT] && cur_stat[NP_BIT];
        if (is_xret) begin
            raw_pc   = use_fatal ? fx_pc : ex_pc;
            ret_stat = use_fatal ? fx_stat : ex_stat;
        end else begin
            raw_pc   = ct_pc;
            ret_stat = ct_stat & STAT_MASK;
        end
        ret_pc = raw_pc & ~ONE;
    end
endmodule

// File: rtl/tbl_branch_unit.sv
module tbl_branch_unit #(
    parameter int            XW        = 32,
    parameter int            IDX_W     = 6,
    parameter int            EP_BIT    = 6,
    parameter int            NP_BIT    = 7,
    parameter logic [XW-1:0] STAT_MASK = XW'(32'h0000_00FF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [XW-1:0] req_pc,
    input  logic [XW-1:0] req_opnd,
    input  logic [XW-1:0] req_stat,
    output logic          busy,
    output logic          mem_rd_valid,
    output logic [XW-1:0] mem_rd_addr,
    input  logic          mem_rd_ready,
    input  logic [15:0]   mem_rd_data,
    output logic          pc_upd,
    output logic [XW-1:0] pc_next,
    output logic          stat_wr,
    output logic [XW-1:0] stat_next,
    output logic [XW-1:0] ctx_pc,
    output logic [XW-1:0] ctx_stat
);
    import tbru_pkg::*;

    localparam logic [XW-1:0] TWO = XW'(2);

    tbru_state_e   state;
    tbru_op_e      op;
    logic          accept;
    logic          lat_call;
    logic [XW-1:0] lat_pc;
    logic [XW-1:0] lat_opnd;
    logic [XW-1:0] base;
    logic [XW-1:0] ex_pc, ex_stat, fx_pc, fx_stat;
    logic [XW-1:0] fetch_addr, target;
    logic [XW-1:0] ret_pc, ret_stat;

    assign op           = tbru_op_e'(req_op);
    assign accept       = req_valid && (state == ST_IDLE);
    assign busy         = (state == ST_FETCH);
    assign mem_rd_valid = busy;
    assign mem_rd_addr  = fetch_addr;

    tbru_ctx_regs #(.XW(XW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_base      (accept && op == OP_SETBASE),
        .base_in      (req_opnd),
        .save_call    (accept && op == OP_TCALL),
        .call_pc_in   (req_pc + TWO),
        .call_stat_in (req_stat),
        .wr_exc       (accept && op == OP_SETEXC),
        .wr_fex       (accept && op == OP_SETFEX),
        .pair_pc_in   (req_opnd),
        .pair_stat_in (req_stat),
        .base         (base),
        .ct_pc        (ctx_pc),
        .ct_stat      (ctx_stat),
        .ex_pc        (ex_pc),
        .ex_stat      (ex_stat),
        .fx_pc        (fx_pc),
        .fx_stat      (fx_stat)
    );

    tbru_addr_gen #(.XW(XW), .IDX_W(IDX_W)) u_addr (
        .is_call    (lat_call),
        .base       (base),
        .pc         (lat_pc),
        .opnd       (lat_opnd),
        .rdata      (mem_rd_data),
        .fetch_addr (fetch_addr),
        .target     (target)
    );

    tbru_ret_sel #(
        .XW(XW), .EP_BIT(EP_BIT), .NP_BIT(NP_BIT), .STAT_MASK(STAT_MASK)
    ) u_ret (
        .is_xret  (op == OP_XRET),
        .cur_stat (req_stat),
        .ct_pc    (ctx_pc),
        .ct_stat  (ctx_stat),
        .ex_pc    (ex_pc),
        .ex_stat  (ex_stat),
        .fx_pc    (fx_pc),
        .fx_stat  (fx_stat),
        .ret_pc   (ret_pc),
        .ret_stat (ret_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            lat_call  <= 1'b0;
            lat_pc    <= '0;
            lat_opnd  <= '0;
            pc_upd    <= 1'b0;
            stat_wr   <= 1'b0;
            pc_next   <= '0;
            stat_next <= '0;
        end else begin
            pc_upd  <= 1'b0;
            stat_wr <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        case (op)
                            OP_TCALL, OP_SWJMP: begin
                                state    <= ST_FETCH;
                                lat_call <= (op == OP_TCALL);
                                lat_pc   <= req_pc;
                                lat_opnd <= req_opnd;
                            end
                            OP_TRET, OP_XRET: begin
                                pc_upd    <= 1'b1;
                                stat_wr   <= 1'b1;
                                pc_next   <= ret_pc;
                                stat_next <= ret_stat;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (mem_rd_ready) begin
                        pc_upd  <= 1'b1;
                        pc_next <= target;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tbru_checker.sv
module tbru_checker #(
    parameter int XW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [2:0]    req_op,
    input logic          busy,
    input logic          mem_rd_valid,
    input logic [XW-1:0] mem_rd_addr,
    input logic          mem_rd_ready,
    input logic          pc_upd,
    input logic          stat_wr,
    input logic [XW-1:0] pc_next
);
    // R2: the read request and its address hold until accepted
    a_r2_read_held: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    // R6: a handshake is followed by the update strobe, without a status write
    a_r6_upd_after_ack: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid && mem_rd_ready |=> pc_upd && !stat_wr);

    // R7: an idle unit given a table operation starts a read next cycle
    a_r7_fetch_starts: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && (req_op == 3'd0 || req_op == 3'd1) |=> mem_rd_valid && busy);

    // R7: no read outstanding while an update strobe is issued
    a_r7_no_fetch_on_upd: assert property (@(posedge clk) disable iff (rst)
        pc_upd |-> !mem_rd_valid);

    // R8: a status restore always travels with a PC update
    a_r8_stat_with_pc: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> pc_upd);

    // R9: return targets are halfword aligned
    a_r9_ret_aligned: assert property (@(posedge clk) disable iff (rst)
        stat_wr |-> pc_next[0] == 1'b0);

    // R10: load and idle operations raise no strobe
    a_r10_no_strobe: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_op[2] |=> !pc_upd && !mem_rd_valid);
endmodule

bind tbl_branch_unit tbru_checker #(.XW(XW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .pc_upd       (pc_upd),
    .stat_wr      (stat_wr),
    .pc_next      (pc_next)
);

// File: tb/tbl_branch_unit_test.sv
module tbl_branch_unit_test;
    localparam int XW = 32;
    localparam logic [31:0] MASK = 32'h0000_0F0F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = 3'd7;
    logic [XW-1:0] req_pc = '0, req_opnd = '0, req_stat = '0;
    logic          busy, mem_rd_valid, pc_upd, stat_wr;
    logic [XW-1:0] mem_rd_addr, pc_next, stat_next, ctx_pc, ctx_stat;
    logic          mem_rd_ready = 1'b0;
    logic [15:0]   mem_rd_data = '0;

    tbl_branch_unit #(.XW(XW), .IDX_W(6), .EP_BIT(6), .NP_BIT(7), .STAT_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_opnd(req_opnd), .req_stat(req_stat),
        .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .pc_upd(pc_upd), .pc_next(pc_next), .stat_wr(stat_wr),
        .stat_next(stat_next), .ctx_pc(ctx_pc), .ctx_stat(ctx_stat)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] stat;
        logic        swr;
        logic [3:0]  req;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] addr_q[$];
    int checks = 0, errors = 0;
    int mem_lat = 0, wait_cnt = 0;
    logic [15:0] mem_word = '0;
    logic [31:0] m_base = '0, m_ctpc = '0, m_ctstat = '0;
    logic [31:0] m_expc = '0, m_exst = '0, m_fxpc = '0, m_fxst = '0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder: checks the read address and answers after mem_lat cycles
    initial forever begin
        @(negedge clk);
        mem_rd_ready = 1'b0;
        if (mem_rd_valid) begin
            if (wait_cnt >= mem_lat) begin
                if (addr_q.size() > 0) begin
                    logic [31:0] ea;
                    ea = addr_q.pop_front();
                    check(mem_rd_addr == ea, "R2/R5 read address", mem_rd_addr, ea);
                end else check(1'b0, "R7 unexpected read", mem_rd_addr, 32'h0);
                mem_rd_data  = mem_word;
                mem_rd_ready = 1'b1;
                wait_cnt = 0;
            end else wait_cnt++;
        end
    end

    // monitor: compares each update strobe against the scoreboard
    initial forever begin
        @(negedge clk);
        if (!rst && pc_upd) begin
            if (sb.size() == 0) check(1'b0, "R7/R10 unexpected strobe", pc_next, 32'h0);
            else begin
                exp_t e;
                e = sb.pop_front();
                check(pc_next == e.pc, $sformatf("R%0d pc_next", e.req), pc_next, e.pc);
                check(stat_wr == e.swr, "R6/R8 stat_wr", {31'b0, stat_wr}, {31'b0, e.swr});
                if (e.swr) check(stat_next == e.stat, $sformatf("R%0d stat_next", e.req), stat_next, e.stat);
            end
        end
    end

    task automatic send(input logic [2:0] op, input logic [31:0] pc, input logic [31:0] opnd, input logic [31:0] st);
        exp_t e;
        logic [31:0] be, ap;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_pc = pc; req_opnd = opnd; req_stat = st;
        be = m_base & ~32'h1;
        ap = pc + 32'd2;
        case (op)
            3'd0: begin // R4
                addr_q.push_back(be + {25'b0, opnd[5:0], 1'b0});
                e = '{pc: be + {16'b0, mem_word & 16'hFFFE}, stat: '0, swr: 1'b0, req: 4'd4};
                sb.push_back(e);
                m_ctpc = ap; m_ctstat = st;
            end
            3'd1: begin // R5
                addr_q.push_back(ap + (opnd << 1));
                e = '{pc: ap + {{15{mem_word[15]}}, mem_word, 1'b0}, stat: '0, swr: 1'b0, req: 4'd5};
                sb.push_back(e);
            end
            3'd2: begin // R8
                e = '{pc: m_ctpc & ~32'h1, stat: m_ctstat & MASK, swr: 1'b1, req: 4'd8};
                sb.push_back(e);
            end
            3'd3: begin // R9
                if (!st[6] && st[7]) e = '{pc: m_fxpc & ~32'h1, stat: m_fxst, swr: 1'b1, req: 4'd9};
                else                 e = '{pc: m_expc & ~32'h1, stat: m_exst, swr: 1'b1, req: 4'd9};
                sb.push_back(e);
            end
            3'd4: m_base = opnd;
            3'd5: begin m_expc = opnd; m_exst = st; end
            3'd6: begin m_fxpc = opnd; m_fxst = st; end
            default: ;
        endcase
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
        check(sb.size() == 0, "R6 strobe count", sb.size(), 32'd0);
    endtask

    bit done = 0;
    initial begin
        #(100000 * 10);
        if (!done) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !mem_rd_valid && !pc_upd && !stat_wr, "R1 strobes low",
              {busy, mem_rd_valid, pc_upd, stat_wr}, 32'h0);
        check(ctx_pc == 0 && ctx_stat == 0, "R1 ctx zero", ctx_pc | ctx_stat, 32'h0);
        rst = 1'b0;

        // R10 base load with odd value, then idle op 7 with garbage
        send(3'd4, 32'h0, 32'h0000_1001, 32'h0);
        send(3'd7, 32'h0000_0111, 32'h0000_0005, 32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        check(!pc_upd && !mem_rd_valid && ctx_pc == 0, "R10 op 7 no effect", ctx_pc, 32'h0);

        // R2 R3 R4 call, zero latency
        mem_lat = 0; mem_word = 16'h0043;
        send(3'd0, 32'h0000_0200, 32'h0000_0045, 32'h1234_5678);
        @(negedge clk);
        check(busy, "R7 busy after call", {31'b0, busy}, 32'h1);
        check(ctx_pc == 32'h0000_0202, "R3 ctx_pc", ctx_pc, 32'h0000_0202);
        check(ctx_stat == 32'h1234_5678, "R3 ctx_stat", ctx_stat, 32'h1234_5678);
        drain();

        // R4 R7 call, max index, odd offset, long wait with dropped request
        mem_lat = 3; mem_word = 16'hFFFF;
        send(3'd0, 32'h0000_0301, 32'h0000_003F, 32'hFFFF_FFFF);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd2;
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        check(busy && mem_rd_valid, "R7 busy held", {30'b0, busy, mem_rd_valid}, 32'h3);
        drain();

        // R5 switch, negative entry and zero index
        mem_lat = 1; mem_word = 16'hFFFE;
        send(3'd1, 32'h0000_4000, 32'h0000_0003, 32'h0);
        drain();
        mem_lat = 2; mem_word = 16'h0010;
        send(3'd1, 32'h0000_5000, 32'h0000_0000, 32'h0);
        drain();

        // R8 table-call return with masking
        send(3'd2, 32'h0, 32'h0, 32'h0);
        drain();

        // R9 exception returns with all flag combinations
        send(3'd5, 32'h0, 32'h0000_5001, 32'hAAAA_5555);
        send(3'd6, 32'h0, 32'h0000_6000, 32'h1111_2222);
        send(3'd3, 32'h0, 32'h0, 32'h0000_0040);
        send(3'd3, 32'h0, 32'h0, 32'h0000_00C0);
        send(3'd3, 32'h0, 32'h0, 32'h0000_0080);
        send(3'd3, 32'h0, 32'h0, 32'h0000_0000);
        drain();

        // R11 back-to-back returns
        send(3'd2, 32'h0, 32'h0, 32'h0);
        send(3'd3, 32'h0, 32'h0, 32'h0000_0080);
        drain();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule